// File: doc/BRIEF.md
# Instruction-Boundary Event Priority Arbiter

This block sits next to a simple processor pipeline model and decides which single event is serviced when an instruction boundary is reached. On each boundary cycle it gathers a pending post-reset event, a system-management request, debug conditions, the two hardware interrupt lines and a set of fault flags from the fetch, decode, coprocessor and memory-operand stages. It qualifies them against the interrupt-enable flag and the coprocessor control bits, and then picks exactly one event under a fixed 14-level order.

The result is a registered 4-bit level code, a take strobe that is high for one cycle, and a one-hot acknowledge that tells the chosen source it was consumed. The non-maskable interrupt is the only edge-type request. It is captured on its rising edge and consumed by its acknowledge. After it is taken, further non-maskable interrupts stay latched but are not served until an end-of-handler pulse. All other requests are levels that are sampled only at the boundary. Faults that lose arbitration are not stored. They are raised again when the pipeline restarts the instruction. The block has no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `evt_prio_arb`

## Requirements
- R1: A low `rst_n` clears the outputs, the captured NMI and the NMI block asynchronously. It also arms a post-reset event, which is reported once, as code 0, at the first boundary after reset.
- R2: Arbitration happens only in a cycle where `boundary_i` is 1. `take_o`, `code_o` and `ack_o` update on the clock edge that ends that cycle and hold for exactly one cycle. If the boundary is absent, or no event is eligible, `take_o` is 0.
- R3: The winner is the eligible event with the lowest level. The levels and codes are: 0 post-reset, 1 system management, 2 debug from the previous instruction, 3 debug breakpoint for the next instruction, 4 NMI, 5 INTR, 6 fetch fault, 7 decode fault, 8 WAIT device-not-available, 9 ESC device-not-available, 10 floating-point error, 11 operand segment fault, 12 operand page fault, 13 alignment check.
- R4: A system-management request wins over every event except the post-reset event.
- R5: When NMI and INTR are both eligible at the same boundary, NMI wins.
- R6: INTR is eligible only when `if_i` is 1.
- R7: A WAIT instruction is eligible only when `ts_i` and `mp_i` are both 1.
- R8: An ESC instruction is eligible when `em_i` or `ts_i` is 1.
- R9: A pending unmasked floating-point exception is eligible only when `ne_i` is 1.
- R10: Each boundary yields at most one event. `ack_o` is one-hot with its bit at index `code_o` when `take_o` is 1, and is all zero otherwise.
- R11: A rising edge on `nmi_i` is captured and stays pending, even after `nmi_i` falls, until it is taken. Taking it clears it.
- R12: Once an NMI is taken, later NMIs are captured but are not eligible until `nmi_done_i` pulses. After that pulse a captured NMI is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary: arbitrate this cycle |
| smi_i | input | 1 | System-management request (level) |
| dbg_prev_i | input | 1 | Debug trap/fault from previous instruction |
| dbg_next_i | input | 1 | Debug breakpoint for next instruction |
| nmi_i | input | 1 | Non-maskable interrupt (edge) |
| nmi_done_i | input | 1 | End of NMI handler pulse |
| intr_i | input | 1 | Maskable interrupt (level) |
| if_i | input | 1 | Interrupt-enable flag |
| ts_i | input | 1 | Task-switched control bit |
| mp_i | input | 1 | Monitor-coprocessor control bit |
| em_i | input | 1 | Emulate-coprocessor control bit |
| ne_i | input | 1 | Native floating-point error reporting bit |
| fetch_flt_i | input | 1 | Fault while fetching next instruction |
| decode_flt_i | input | 1 | Fault while decoding |
| wait_ins_i | input | 1 | Current instruction is WAIT |
| esc_ins_i | input | 1 | Current instruction is a coprocessor ESC |
| fp_exc_i | input | 1 | Pending unmasked floating-point exception |
| seg_flt_i | input | 1 | Operand segmentation fault |
| page_flt_i | input | 1 | Operand page fault |
| align_flt_i | input | 1 | Alignment check fault |
| take_o | output | 1 | One-cycle event strobe |
| code_o | output | 4 | Level code of the taken event |
| ack_o | output | 14 | One-hot acknowledge to the taken source |

## Verification
Assertions check several rules on every cycle. The acknowledge is one-hot and matches the code and the strobe. A strobe only follows a boundary cycle. An INTR win implies the enable flag was set. An NMI win implies no block was in force. A rising NMI edge always leaves a captured request. The qualification rules and the full priority order can only be shown by the bench scenarios. The bench sweeps every combination of the level requests and control bits and compares each result with an arithmetic model. It also covers the ordered NMI sequences: capture without a boundary, blocking, release by the handler-done pulse, and clearing by reset.

// File: rtl/evt_prio_pkg.sv
package evt_prio_pkg;
  localparam int NLEV = 14;
  localparam int CW   = $clog2(NLEV);
  localparam int L_RST   = 0;
  localparam int L_SMI   = 1;
  localparam int L_DBGP  = 2;
  localparam int L_DBGN  = 3;
  localparam int L_NMI   = 4;
  localparam int L_INTR  = 5;
  localparam int L_FETCH = 6;
  localparam int L_DEC   = 7;
  localparam int L_WAIT  = 8;
  localparam int L_ESC   = 9;
  localparam int L_FPE   = 10;
  localparam int L_SEG   = 11;
  localparam int L_PAGE  = 12;
  localparam int L_ALIGN = 13;
endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_prio_pkg::*;
(
  input  logic            rst_evt_i,
  input  logic            smi_i,
  input  logic            dbg_prev_i,
  input  logic            dbg_next_i,
  input  logic            nmi_elig_i,
  input  logic            intr_i,
  input  logic            if_i,
  input  logic            ts_i,
  input  logic            mp_i,
  input  logic            em_i,
  input  logic            ne_i,
  input  logic            fetch_flt_i,
  input  logic            decode_flt_i,
  input  logic            wait_ins_i,
  input  logic            esc_ins_i,
  input  logic            fp_exc_i,
  input  logic            seg_flt_i,
  input  logic            page_flt_i,
  input  logic            align_flt_i,
  output logic [NLEV-1:0] req_o
);
  always_comb begin
    req_o          = '0;
    req_o[L_RST]   = rst_evt_i;
    req_o[L_SMI]   = smi_i;
    req_o[L_DBGP]  = dbg_prev_i;
    req_o[L_DBGN]  = dbg_next_i;
    req_o[L_NMI]   = nmi_elig_i;
    req_o[L_INTR]  = intr_i & if_i;
    req_o[L_FETCH] = fetch_flt_i;
    req_o[L_DEC]   = decode_flt_i;
    req_o[L_WAIT]  = wait_ins_i & ts_i & mp_i;
    req_o[L_ESC]   = esc_ins_i & (em_i | ts_i);
    req_o[L_FPE]   = fp_exc_i & ne_i;
    req_o[L_SEG]   = seg_flt_i;
    req_o[L_PAGE]  = page_flt_i;
    req_o[L_ALIGN] = align_flt_i;
  end
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
  parameter int N  = 14,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [CW-1:0] code_o,
  output logic          any_o
);
  logic [N:0] higher;
  assign higher[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant_o[g]  = req_i[g] & ~higher[g];
    assign higher[g+1] = higher[g] | req_i[g];
  end
  assign any_o = higher[N];

  always_comb begin
    code_o = '0;
    for (int k = 0; k < N; k++)
      if (grant_o[k]) code_o = CW'(k);
  end
endmodule

// File: rtl/evt_nmi_ctl.sv
module evt_nmi_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic done_i,
  input  logic taken_i,
  output logic elig_o,
  output logic block_o
);
  logic nmi_q, pend_q, rise;

  assign rise   = nmi_i & ~nmi_q;
  assign elig_o = pend_q & ~block_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q   <= 1'b0;
      pend_q  <= 1'b0;
      block_o <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (rise)         pend_q <= 1'b1;
      else if (taken_i) pend_q <= 1'b0;
      if (taken_i)      block_o <= 1'b1;
      else if (done_i)  block_o <= 1'b0;
    end
  end

  // R11
  nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !nmi_q) |=> pend_q);
endmodule

// File: rtl/evt_prio_arb.sv
module evt_prio_arb
  import evt_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary_i,
  input  logic            smi_i,
  input  logic            dbg_prev_i,
  input  logic            dbg_next_i,
  input  logic            nmi_i,
  input  logic            nmi_done_i,
  input  logic            intr_i,
  input  logic            if_i,
  input  logic            ts_i,
  input  logic            mp_i,
  input  logic            em_i,
  input  logic            ne_i,
  input  logic            fetch_flt_i,
  input  logic            decode_flt_i,
  input  logic            wait_ins_i,
  input  logic            esc_ins_i,
  input  logic            fp_exc_i,
  input  logic            seg_flt_i,
  input  logic            page_flt_i,
  input  logic            align_flt_i,
  output logic            take_o,
  output logic [CW-1:0]   code_o,
  output logic [NLEV-1:0] ack_o
);
  logic            rst_evt_q;
  logic            nmi_elig, nmi_block;
  logic [NLEV-1:0] req, grant;
  logic [CW-1:0]   win_code;
  logic            any;
  logic            fire;

  assign fire = boundary_i & any;

  evt_nmi_ctl u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_i   (nmi_i),
    .done_i  (nmi_done_i),
    .taken_i (boundary_i & grant[L_NMI]),
    .elig_o  (nmi_elig),
    .block_o (nmi_block)
  );

  evt_qualify u_qual (
    .rst_evt_i   (rst_evt_q),
    .smi_i       (smi_i),
    .dbg_prev_i  (dbg_prev_i),
    .dbg_next_i  (dbg_next_i),
    .nmi_elig_i  (nmi_elig),
    .intr_i      (intr_i),
    .if_i        (if_i),
    .ts_i        (ts_i),
    .mp_i        (mp_i),
    .em_i        (em_i),
    .ne_i        (ne_i),
    .fetch_flt_i (fetch_flt_i),
    .decode_flt_i(decode_flt_i),
    .wait_ins_i  (wait_ins_i),
    .esc_ins_i   (esc_ins_i),
    .fp_exc_i    (fp_exc_i),
    .seg_flt_i   (seg_flt_i),
    .page_flt_i  (page_flt_i),
    .align_flt_i (align_flt_i),
    .req_o       (req)
  );

  evt_prio_pick #(.N(NLEV), .CW(CW)) u_pick (
    .req_i   (req),
    .grant_o (grant),
    .code_o  (win_code),
    .any_o   (any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_evt_q <= 1'b1;
      take_o    <= 1'b0;
      code_o    <= '0;
      ack_o     <= '0;
    end else begin
      if (boundary_i && grant[L_RST]) rst_evt_q <= 1'b0;
      take_o <= fire;
      code_o <= fire ? win_code : '0;
      ack_o  <= fire ? grant : '0;
    end
  end

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o) && (take_o == (ack_o != '0)));
  // R10
  ack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ack_o[code_o]);
  // R2
  take_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));
  // R6
  intr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && code_o == CW'(L_INTR)) |-> $past(if_i));
  // R12
  nmi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && code_o == CW'(L_NMI)) |-> !$past(nmi_block));
endmodule

// File: tb/test_evt_prio_arb.sv
module test_evt_prio_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 0, smi_i = 0, dbg_prev_i = 0, dbg_next_i = 0;
  logic nmi_i = 0, nmi_done_i = 0, intr_i = 0, if_i = 0;
  logic ts_i = 0, mp_i = 0, em_i = 0, ne_i = 0;
  logic fetch_flt_i = 0, decode_flt_i = 0, wait_ins_i = 0, esc_ins_i = 0;
  logic fp_exc_i = 0, seg_flt_i = 0, page_flt_i = 0, align_flt_i = 0;
  logic        take_o;
  logic [3:0]  code_o;
  logic [13:0] ack_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  evt_prio_arb i_evt_prio_arb (.*);

  // Expected winner from a 17-bit vector: [3:0]=ts,mp,em,ne; [16:4]=
  // smi,dbgp,dbgn,intr,if,fetch,dec,wait,esc,fp,seg,page,align
  function automatic int model(input logic [16:0] v);
    logic ts, mp, em, ne;
    logic [13:0] r;
    ts = v[0]; mp = v[1]; em = v[2]; ne = v[3];
    r = '0;
    r[1]  = v[4];
    r[2]  = v[5];
    r[3]  = v[6];
    r[5]  = v[7] & v[8];
    r[6]  = v[9];
    r[7]  = v[10];
    r[8]  = v[11] & ts & mp;
    r[9]  = v[12] & (em | ts);
    r[10] = v[13] & ne;
    r[11] = v[14];
    r[12] = v[15];
    r[13] = v[16];
    for (int k = 0; k < 14; k++) if (r[k]) return k;
    return -1;
  endfunction

  function automatic string req_of(input int l);
    case (l)
      -1: return "R2";
      1:  return "R4";
      5:  return "R6";
      8:  return "R7";
      9:  return "R8";
      10: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic apply(input logic [16:0] v);
    {align_flt_i, page_flt_i, seg_flt_i, fp_exc_i, esc_ins_i, wait_ins_i,
     decode_flt_i, fetch_flt_i, if_i, intr_i, dbg_next_i, dbg_prev_i, smi_i} = v[16:4];
    {ne_i, em_i, mp_i, ts_i} = v[3:0];
  endtask

  task automatic check(input string req, input int exp);
    logic [13:0] eack;
    logic        etake;
    etake = (exp >= 0);
    eack  = etake ? (14'd1 << exp) : 14'd0;
    checks++;
    if (take_o !== etake || ack_o !== eack || (etake && code_o !== 4'(exp))) begin
      fails++;
      $display("FAIL %s: take=%0b code=%0d ack=%h expected take=%0b code=%0d ack=%h",
               req, take_o, code_o, ack_o, etake, exp, eack);
    end
  endtask

  // one boundary cycle, then look at the registered result
  task automatic boundary_step(input string req, input int exp);
    boundary_i = 1;
    @(negedge clk);
    boundary_i = 0;
    check(req, exp);
  endtask

  initial begin
    #1;
    check("R1", -1);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", -1);
    // no boundary: nothing taken (R2)
    smi_i = 1;
    @(negedge clk);
    check("R2", -1);
    smi_i = 0;
    // post-reset event wins over SMI once (R1, R4)
    smi_i = 1;
    boundary_i = 1;
    @(negedge clk);
    check("R1", 0);
    @(negedge clk);
    boundary_i = 0;
    check("R4", 1);
    smi_i = 0;
    @(negedge clk);
    check("R2", -1);

    // exhaustive sweep, pipelined one vector per cycle (R3..R10)
    begin
      logic [16:0] prev;
      prev = '0;
      for (int i = 0; i < (1 << 17); i++) begin
        apply(17'(i));
        boundary_i = 1;
        @(negedge clk);
        check(req_of(model(17'(i))), model(17'(i)));
        prev = 17'(i);
      end
      boundary_i = 0;
      apply('0);
      @(negedge clk);
      check("R2", -1);
      if (prev == 0) check("R3", -1);
    end

    // NMI versus INTR; edge captured without boundary (R5, R11)
    nmi_i = 1;
    @(negedge clk);
    nmi_i = 0;
    @(negedge clk);
    check("R11", -1);
    intr_i = 1; if_i = 1;
    boundary_i = 1;
    @(negedge clk);
    check("R5", 4);
    // captured request cleared by the take
    @(negedge clk);
    boundary_i = 0;
    check("R11", 5);
    // new edge while blocked: INTR wins (R12)
    nmi_i = 1;
    @(negedge clk);
    nmi_i = 0;
    boundary_step("R12", 5);
    intr_i = 0;
    boundary_step("R12", -1);
    // handler done releases the captured NMI
    nmi_done_i = 1;
    @(negedge clk);
    nmi_done_i = 0;
    boundary_step("R12", 4);
    boundary_step("R11", -1);

    // reset clears a captured NMI (R1)
    nmi_done_i = 1;
    @(negedge clk);
    nmi_done_i = 0;
    nmi_i = 1;
    @(negedge clk);
    nmi_i = 0;
    #1 rst_n = 0;
    #1;
    check("R1", -1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    boundary_step("R1", 0);
    boundary_step("R1", -1);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule